// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Access-Rights Checking

This block sits between a processor's address generation and its physically addressed memory path. Each request carries a virtual address and an access kind (load, store or instruction fetch). The virtual page number is split into a set index (its low bits) and a tag (the rest). The ways of the selected set are compared in parallel. On a matching entry whose rights permit the access, the block returns the physical address, which is the stored physical page number joined to the untouched page offset. All of this happens in the same cycle as the request.

Every entry keeps a valid flag, a modified (dirty) flag, a recently-used (reference) flag, a three-bit rights field, a tag and a physical page number. A hit that the rights forbid raises a protection fault instead of a hit. A missing translation raises a miss, and an external page-table walker then installs the entry through the refill port. The refill port reports a modified victim so that its page can be written back. A context-switch input drops every translation. A periodic clear input wipes all reference flags, so that replacement can tell recently used pages from idle ones.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any request reports a miss.
- R2: The set index is the low IDX_W bits of the virtual page number (the address bits just above the page offset), and the tag is the remaining upper bits. The ways of one set hold different tags at the same time. A request with the right index but no matching tag misses, and a matching tag in a different set does not hit.
- R3: On a hit, rsp_paddr equals the stored physical page number concatenated with the request's page offset, which passes through bit for bit.
- R4: For every valid request, exactly one of rsp_hit, rsp_miss and rsp_fault is high in the same cycle. With req_valid low, all three are low, and rsp_paddr is zero whenever rsp_hit is low.
- R5: The rights field has bit 0 = read allowed, bit 1 = write allowed and bit 2 = execute allowed. req_kind is encoded 0 = load, 1 = store, 2 = fetch and 3 = reserved. Each of the first three kinds needs its own bit, and the reserved kind is always denied. A denied access to a present entry gives rsp_fault.
- R6: A permitted access sets the entry's reference flag. rsp_ref and rsp_dirty show the entry's flags as they were before the current access.
- R7: A permitted store sets the entry's dirty flag. Loads and fetches leave it unchanged.
- R8: A faulting access changes neither the reference nor the dirty flag.
- R9: A pulse on ref_clear clears the reference flag of every entry.
- R10: A pulse on ctx_switch invalidates every entry by the next cycle. A refill presented in the same cycle is discarded.
- R11: A refill overwrites the way that already holds the same page, if there is one. Otherwise it takes the lowest invalid way. Otherwise it takes the lowest way whose reference flag is clear. Otherwise it takes the way named by that set's round-robin pointer, which then advances by one.
- R12: A refill starts the entry with clear reference and dirty flags. In the refill cycle, if it displaces a valid dirty entry, evict_wb is high and evict_vpn/evict_ppn name the displaced translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | VA_W | Virtual address of the request |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No matching translation |
| rsp_fault | output | 1 | Translation found but access denied |
| rsp_paddr | output | PA_W | Physical address, valid with rsp_hit |
| rsp_ref | output | 1 | Matching entry's reference flag before this access |
| rsp_dirty | output | 1 | Matching entry's dirty flag before this access |
| fill_valid | input | 1 | Refill entry present |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| fill_rights | input | 3 | Rights to install (bit0 R, bit1 W, bit2 X) |
| ctx_switch | input | 1 | Invalidate all entries |
| ref_clear | input | 1 | Clear all reference flags |
| evict_wb | output | 1 | Refill displaces a valid dirty entry |
| evict_vpn | output | VPN_W | Page number of the displaced entry |
| evict_ppn | output | PPN_W | Physical page of the displaced entry |

## Verification
The hit, miss, fault, address and flag outputs depend combinationally on the request, so they are due in the request's own cycle. The eviction report likewise appears in the refill's own cycle. Stored effects (flag updates, installs, invalidation, reference clearing) become visible only on a request presented after the next rising edge. The bench changes inputs on the falling edge and reads outputs one nanosecond later. Every operation therefore spans exactly one rising edge, and each check of a stored effect uses a separate later lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam int RIGHT_R = 0;
    localparam int RIGHT_W = 1;
    localparam int RIGHT_X = 2;
    localparam int RIGHTS_W = 3;
endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [RIGHTS_W-1:0] rights,
    input  logic [1:0]          kind,
    output logic                allow
);
    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_LOAD:  allow = rights[RIGHT_R];
            ACC_STORE: allow = rights[RIGHT_W];
            ACC_FETCH: allow = rights[RIGHT_X];
            ACC_RSVD:  allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 18,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]       vld,
    input  logic [WAYS*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]      tag,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  hit,
    output logic [WAY_W-1:0]      way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g*TAG_W +: TAG_W] == tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int WAYS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  vld,
    input  logic [WAYS-1:0]  refd,
    input  logic [WAY_W-1:0] rr_ptr,
    input  logic             dup_hit,
    input  logic [WAY_W-1:0] dup_way,
    output logic [WAY_W-1:0] way,
    output logic             use_rr
);
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] idle_way;

    always_comb begin
        free_way = '0;
        idle_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w])  free_way = WAY_W'(w);
            if (!refd[w]) idle_way = WAY_W'(w);
        end
    end

    always_comb begin
        use_rr = 1'b0;
        if (dup_hit)            way = dup_way;
        else if (!(&vld))       way = free_way;
        else if (!(&refd))      way = idle_way;
        else begin
            way    = rr_ptr;
            use_rr = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W      = 40,
    parameter int PA_W      = 36,
    parameter int PAGE_BITS = 14,
    parameter int ENTRIES   = 512,
    parameter int WAYS      = 2,
    localparam int VPN_W = VA_W - PAGE_BITS,
    localparam int PPN_W = PA_W - PAGE_BITS,
    localparam int SETS  = ENTRIES / WAYS,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = VPN_W - IDX_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_ref,
    output logic             rsp_dirty,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [2:0]       fill_rights,
    input  logic             ctx_switch,
    input  logic             ref_clear,
    output logic             evict_wb,
    output logic [VPN_W-1:0] evict_vpn,
    output logic [PPN_W-1:0] evict_ppn
);
    // Entry storage: flags reset, payload does not
    logic [WAYS-1:0]     vld_q [SETS];
    logic [WAYS-1:0]     ref_q [SETS];
    logic [WAYS-1:0]     dty_q [SETS];
    logic [WAY_W-1:0]    rr_q  [SETS];
    logic [TAG_W-1:0]    tag_q [SETS][WAYS];
    logic [PPN_W-1:0]    ppn_q [SETS][WAYS];
    logic [RIGHTS_W-1:0] rgt_q [SETS][WAYS];

    // Lookup side
    logic [VPN_W-1:0]      lk_vpn;
    logic [IDX_W-1:0]      lk_idx;
    logic [TAG_W-1:0]      lk_tag;
    logic [PAGE_BITS-1:0]  lk_off;
    logic [WAYS*TAG_W-1:0] lk_tags;
    logic [WAYS-1:0]       lk_hit_vec;
    logic                  lk_hit;
    logic [WAY_W-1:0]      lk_way;
    logic                  lk_allow;

    assign lk_vpn = req_vaddr[VA_W-1:PAGE_BITS];
    assign lk_off = req_vaddr[PAGE_BITS-1:0];
    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) lk_tags[w*TAG_W +: TAG_W] = tag_q[lk_idx][w];
    end

    tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .vld(vld_q[lk_idx]), .tags(lk_tags), .tag(lk_tag),
        .hit_vec(lk_hit_vec), .hit(lk_hit), .way(lk_way)
    );

    tlb_perm u_perm (
        .rights(rgt_q[lk_idx][lk_way]), .kind(req_kind), .allow(lk_allow)
    );

    always_comb begin
        rsp_hit   = req_valid && lk_hit && lk_allow;
        rsp_fault = req_valid && lk_hit && !lk_allow;
        rsp_miss  = req_valid && !lk_hit;
        rsp_paddr = rsp_hit ? {ppn_q[lk_idx][lk_way], lk_off} : '0;
        rsp_ref   = (req_valid && lk_hit) ? ref_q[lk_idx][lk_way] : 1'b0;
        rsp_dirty = (req_valid && lk_hit) ? dty_q[lk_idx][lk_way] : 1'b0;
    end

    // Refill side
    logic [IDX_W-1:0]      f_idx;
    logic [TAG_W-1:0]      f_tag;
    logic [WAYS*TAG_W-1:0] f_tags;
    logic [WAYS-1:0]       f_dup_vec;
    logic                  f_dup;
    logic [WAY_W-1:0]      f_dup_way;
    logic [WAY_W-1:0]      f_way;
    logic                  f_use_rr;
    logic                  f_take;

    assign f_idx  = fill_vpn[IDX_W-1:0];
    assign f_tag  = fill_vpn[VPN_W-1:IDX_W];
    assign f_take = fill_valid && !ctx_switch;

    always_comb begin
        for (int w = 0; w < WAYS; w++) f_tags[w*TAG_W +: TAG_W] = tag_q[f_idx][w];
    end

    tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_match (
        .vld(vld_q[f_idx]), .tags(f_tags), .tag(f_tag),
        .hit_vec(f_dup_vec), .hit(f_dup), .way(f_dup_way)
    );

    tlb_victim #(.WAYS(WAYS)) u_victim (
        .vld(vld_q[f_idx]), .refd(ref_q[f_idx]), .rr_ptr(rr_q[f_idx]),
        .dup_hit(f_dup), .dup_way(f_dup_way), .way(f_way), .use_rr(f_use_rr)
    );

    always_comb begin
        evict_wb  = f_take && !f_dup && vld_q[f_idx][f_way] && dty_q[f_idx][f_way];
        evict_vpn = {tag_q[f_idx][f_way], f_idx};
        evict_ppn = ppn_q[f_idx][f_way];
    end

    // Flag state: clear, then access update, then refill, then flush wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                ref_q[s] <= '0;
                dty_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else begin
            if (ref_clear) begin
                for (int s = 0; s < SETS; s++) ref_q[s] <= '0;
            end
            if (rsp_hit) begin
                ref_q[lk_idx][lk_way] <= 1'b1;
                if (req_kind == ACC_STORE) dty_q[lk_idx][lk_way] <= 1'b1;
            end
            if (f_take) begin
                vld_q[f_idx][f_way] <= 1'b1;
                ref_q[f_idx][f_way] <= 1'b0;
                dty_q[f_idx][f_way] <= 1'b0;
                if (f_use_rr)
                    rr_q[f_idx] <= (rr_q[f_idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[f_idx] + 1'b1;
            end
            if (ctx_switch) begin
                for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (f_take) begin
            tag_q[f_idx][f_way] <= f_tag;
            ppn_q[f_idx][f_way] <= fill_ppn;
            rgt_q[f_idx][f_way] <= fill_rights;
        end
    end

    // R4
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(rsp_hit || rsp_miss || rsp_fault));
    // R10
    flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_switch |=> (!req_valid || rsp_miss));
    // R7
    dirty_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && req_kind == ACC_STORE && !ctx_switch && !fill_valid) |=>
        (!(req_valid && lk_hit && lk_vpn == $past(lk_vpn)) || rsp_dirty));
    // R8
    fault_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && !ctx_switch && !fill_valid && !ref_clear) |=>
        (!(req_valid && lk_hit && lk_vpn == $past(lk_vpn)) ||
         (rsp_ref == $past(rsp_ref) && rsp_dirty == $past(rsp_dirty))));
    // R11
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(lk_hit_vec));
endmodule

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
    localparam int VA_W = 40, PA_W = 36, PB = 14, VPN_W = 26, PPN_W = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             req_valid = 0;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic [1:0]       req_kind = '0;
    logic             rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_dirty;
    logic [PA_W-1:0]  rsp_paddr;
    logic             fill_valid = 0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic [2:0]       fill_rights = '0;
    logic             ctx_switch = 0, ref_clear = 0;
    logic             evict_wb;
    logic [VPN_W-1:0] evict_vpn;
    logic [PPN_W-1:0] evict_ppn;

    tlb_xlate u0 (.*);

    int tests = 0, fails = 0;
    bit done = 0;

    // sampled outputs
    logic o_hit, o_miss, o_fault, o_ref, o_dty, o_ewb;
    logic [PA_W-1:0]  o_pa;
    logic [VPN_W-1:0] o_evpn;
    logic [PPN_W-1:0] o_eppn;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2, RS = 2'd3;

    function automatic logic [VPN_W-1:0] vpn_of(input logic [17:0] tag, input logic [7:0] idx);
        return {tag, idx};
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic cycle(input logic rv, input logic [VA_W-1:0] va, input logic [1:0] k,
                         input logic fv, input logic [VPN_W-1:0] fvpn, input logic [PPN_W-1:0] fppn,
                         input logic [2:0] frt, input logic cs, input logic rc);
        @(negedge clk);
        req_valid = rv; req_vaddr = va; req_kind = k;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_rights = frt;
        ctx_switch = cs; ref_clear = rc;
        #1;
        o_hit = rsp_hit; o_miss = rsp_miss; o_fault = rsp_fault; o_pa = rsp_paddr;
        o_ref = rsp_ref; o_dty = rsp_dirty;
        o_ewb = evict_wb; o_evpn = evict_vpn; o_eppn = evict_ppn;
        @(posedge clk);
    endtask

    task automatic idle();
        cycle(0, '0, LD, 0, '0, '0, '0, 0, 0);
    endtask
    task automatic look(input logic [VPN_W-1:0] vpn, input logic [PB-1:0] off, input logic [1:0] k);
        cycle(1, {vpn, off}, k, 0, '0, '0, '0, 0, 0);
    endtask
    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn, input logic [2:0] rt);
        cycle(0, '0, LD, 1, vpn, ppn, rt, 0, 0);
    endtask

    // expect a result kind: 0 hit, 1 miss, 2 fault
    task automatic expect_res(input string rq, input int res);
        check(o_hit == (res == 0), rq, "hit", 64'(o_hit), 64'(res == 0));
        check(o_miss == (res == 1), rq, "miss", 64'(o_miss), 64'(res == 1));
        check(o_fault == (res == 2), rq, "fault", 64'(o_fault), 64'(res == 2));
    endtask

    task automatic expect_pa(input string rq, input logic [PPN_W-1:0] ppn, input logic [PB-1:0] off);
        check(o_pa == {ppn, off}, rq, "paddr", 64'(o_pa), 64'({ppn, off}));
    endtask

    task automatic t_reset();
        idle();
        check(!o_hit && !o_miss && !o_fault && o_pa == '0, "R4", "idle outputs", 64'({o_hit, o_miss, o_fault}), 0);
        look(vpn_of(18'h155, 8'd5), 14'h0ABC, LD);
        expect_res("R1", 1);
        check(o_pa == '0, "R4", "paddr on miss", 64'(o_pa), 0);
    endtask

    task automatic t_index_tag();
        fill(vpn_of(18'h155, 8'd5), 22'h12345, 3'b011);
        look(vpn_of(18'h155, 8'd5), 14'h0ABC, LD);
        expect_res("R2", 0);
        expect_pa("R3", 22'h12345, 14'h0ABC);
        look(vpn_of(18'h155, 8'd5), 14'h3FFF, LD);
        expect_pa("R3", 22'h12345, 14'h3FFF);
        fill(vpn_of(18'h2AA, 8'd5), 22'h0BEEF, 3'b111);
        look(vpn_of(18'h2AA, 8'd5), 14'h0001, LD);
        expect_res("R2", 0);
        expect_pa("R3", 22'h0BEEF, 14'h0001);
        look(vpn_of(18'h155, 8'd5), 14'h0000, LD);
        expect_res("R2", 0);
        look(vpn_of(18'h100, 8'd5), 14'h0000, LD);
        expect_res("R2", 1);
        look(vpn_of(18'h155, 8'd6), 14'h0000, LD);
        expect_res("R2", 1);
    endtask

    task automatic t_perm();
        fill(vpn_of(18'h3, 8'd20), 22'h77, 3'b001);
        look(vpn_of(18'h3, 8'd20), 14'h10, ST);
        expect_res("R5", 2);
        check(o_pa == '0, "R4", "paddr on fault", 64'(o_pa), 0);
        look(vpn_of(18'h3, 8'd20), 14'h10, LD);
        expect_res("R5", 0);
        check(o_ref == 0 && o_dty == 0, "R8", "flags after fault", 64'({o_ref, o_dty}), 0);
        look(vpn_of(18'h3, 8'd20), 14'h10, FE);
        expect_res("R5", 2);
        look(vpn_of(18'h3, 8'd20), 14'h10, RS);
        expect_res("R5", 2);
        look(vpn_of(18'h2AA, 8'd5), 14'h20, FE);
        expect_res("R5", 0);
        look(vpn_of(18'h155, 8'd5), 14'h20, FE);
        expect_res("R5", 2);
    endtask

    task automatic t_flags();
        fill(vpn_of(18'h7, 8'd30), 22'h4D, 3'b011);
        look(vpn_of(18'h7, 8'd30), 14'h0, LD);
        check(o_ref == 0 && o_dty == 0, "R6", "fresh flags", 64'({o_ref, o_dty}), 0);
        look(vpn_of(18'h7, 8'd30), 14'h0, LD);
        check(o_ref == 1, "R6", "ref after load", 64'(o_ref), 1);
        check(o_dty == 0, "R7", "dirty after load", 64'(o_dty), 0);
        look(vpn_of(18'h7, 8'd30), 14'h0, ST);
        expect_res("R7", 0);
        check(o_dty == 0, "R6", "dirty shown before store", 64'(o_dty), 0);
        look(vpn_of(18'h7, 8'd30), 14'h0, LD);
        check(o_dty == 1, "R7", "dirty after store", 64'(o_dty), 1);
        cycle(0, '0, LD, 0, '0, '0, '0, 0, 1);
        look(vpn_of(18'h7, 8'd30), 14'h0, LD);
        check(o_ref == 0, "R9", "ref after clear", 64'(o_ref), 0);
        check(o_dty == 1, "R9", "dirty kept by clear", 64'(o_dty), 1);
    endtask

    task automatic t_replace();
        fill(vpn_of(18'h10, 8'd9), 22'h100, 3'b011);
        fill(vpn_of(18'h11, 8'd9), 22'h101, 3'b011);
        look(vpn_of(18'h10, 8'd9), 14'h0, LD);
        fill(vpn_of(18'h12, 8'd9), 22'h102, 3'b011);
        check(o_ewb == 0, "R12", "clean victim no writeback", 64'(o_ewb), 0);
        look(vpn_of(18'h11, 8'd9), 14'h0, LD);
        expect_res("R11", 1);
        look(vpn_of(18'h10, 8'd9), 14'h0, ST);
        expect_res("R11", 0);
        look(vpn_of(18'h12, 8'd9), 14'h0, LD);
        expect_res("R11", 0);
        fill(vpn_of(18'h13, 8'd9), 22'h103, 3'b011);
        check(o_ewb == 1, "R12", "dirty victim writeback", 64'(o_ewb), 1);
        check(o_evpn == vpn_of(18'h10, 8'd9), "R12", "evict vpn", 64'(o_evpn), 64'(vpn_of(18'h10, 8'd9)));
        check(o_eppn == 22'h100, "R12", "evict ppn", 64'(o_eppn), 64'h100);
        look(vpn_of(18'h10, 8'd9), 14'h0, LD);
        expect_res("R11", 1);
        look(vpn_of(18'h13, 8'd9), 14'h5, LD);
        expect_res("R11", 0);
        expect_pa("R11", 22'h103, 14'h5);
        look(vpn_of(18'h12, 8'd9), 14'h0, LD);
        expect_res("R11", 0);
        fill(vpn_of(18'h14, 8'd9), 22'h104, 3'b011);
        look(vpn_of(18'h12, 8'd9), 14'h0, LD);
        expect_res("R11", 1);
        look(vpn_of(18'h13, 8'd9), 14'h0, LD);
        expect_res("R11", 0);
        look(vpn_of(18'h14, 8'd9), 14'h0, LD);
        expect_res("R11", 0);
        fill(vpn_of(18'h13, 8'd9), 22'h1FF, 3'b011);
        look(vpn_of(18'h13, 8'd9), 14'h6, LD);
        expect_pa("R11", 22'h1FF, 14'h6);
        check(o_ref == 0, "R12", "ref clear after refill", 64'(o_ref), 0);
        look(vpn_of(18'h14, 8'd9), 14'h0, LD);
        expect_res("R11", 0);
    endtask

    task automatic t_flush();
        cycle(0, '0, LD, 0, '0, '0, '0, 1, 0);
        look(vpn_of(18'h155, 8'd5), 14'h0, LD);
        expect_res("R10", 1);
        look(vpn_of(18'h14, 8'd9), 14'h0, LD);
        expect_res("R10", 1);
        cycle(0, '0, LD, 1, vpn_of(18'h155, 8'd5), 22'h222, 3'b011, 1, 0);
        look(vpn_of(18'h155, 8'd5), 14'h0, LD);
        expect_res("R10", 1);
        fill(vpn_of(18'h155, 8'd5), 22'h222, 3'b011);
        look(vpn_of(18'h155, 8'd5), 14'h0, ST);
        expect_res("R10", 0);
        check(o_ref == 0 && o_dty == 0, "R12", "refilled flags", 64'({o_ref, o_dty}), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_index_tag();
        t_perm();
        t_flags();
        t_replace();
        t_flush();
        idle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule